// File: doc/BRIEF.md
# Memory Error Counter Bank

This block tallies the error events that an ECC checker raises while reading memory. Each event is a single-cycle valid pulse that carries a kind (correctable or uncorrectable), a flag saying whether the location is known, and a channel number and a slot number. The bank updates several counters from each event:

- a pair of counters for every module;
- a pair for every slot position, shared by all channels;
- controller-wide totals;
- a pair for events whose location is missing or cannot be used.

A seconds counter advances on an external one-second tick. It shows how long it has been since the counters were last cleared.

A host reads any counter through an address-decoded read port with one cycle of latency. A single clear pulse zeroes every counter and the seconds counter together. Every counter stops at its largest value instead of wrapping back to zero. The defaults describe three channels with three slots each and 16-bit counters.

Top module: `memerr_count_bank`

## Requirements
- R1: An event whose location is usable (err_has_loc=1, err_chan<3, err_slot<3) increments the module counter at address (err_chan*3+err_slot)*2+k. Here k=0 for a correctable event (err_uncorr=0) and k=1 for an uncorrectable one. No other module counter changes.
- R2: A usable event also increments the slot counter at address 18+err_slot*2+k. The channel does not matter, so the same slot number on every channel feeds the same slot counter.
- R3: Every event increments a total counter: address 24 for correctable, address 25 for uncorrectable. Events with or without a location are both counted.
- R4: An event whose location is missing or out of range increments the no-location counter at address 26+k. It is counted at address 26 for correctable and 27 for uncorrectable. Such an event changes no module counter and no slot counter. A location is out of range when err_has_loc=0, err_chan>=3 or err_slot>=3.
- R5: Every cycle with sec_tick high increments the seconds counter at address 28.
- R6: A cycle with clr high zeroes every counter and the seconds counter. The zeros are readable from the following cycle.
- R7: An event or a tick that arrives in the same cycle as clr is dropped. The clear wins.
- R8: All counters, including the seconds counter, saturate at 0xFFFF and stay there.
- R9: With rd_en high, rd_data shows the addressed counter one cycle later. Addresses 29 to 31 read as zero. While rd_en is low, rd_data holds its last value.
- R10: After reset, all counters and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle error event strobe |
| err_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_has_loc | input | 1 | Location fields are meaningful |
| err_chan | input | 2 | Channel of the failing module |
| err_slot | input | 2 | Slot of the failing module within its channel |
| sec_tick | input | 1 | One-second pulse |
| clr | input | 1 | Clear all counters and the seconds count |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Counter address |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions check, on every cycle:
- that each counter steps by exactly one, holds at its ceiling, and drops to zero after a clear;
- that the decoder raises at most one module increment at a time, and none during a clear;
- that every total increment is matched by either a module increment or a no-location increment;
- that idle read data stays put.

Only the bench scenarios can show the address map: which register a given channel, slot and kind lands in. They also show that slot counters merge events across channels, and that out-of-range locations are routed to the no-location pair. Finally, they show the end-to-end value reached after a full run to saturation.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  typedef enum logic {
    KIND_CORR   = 1'b0,
    KIND_UNCORR = 1'b1
  } err_kind_e;

  localparam int KINDS = 2;
endpackage

// File: rtl/memerr_sat_ctr.sv
module memerr_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + W'(1);
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> count == '0);
  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count == TOP) |=> count == TOP);
  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != TOP) |=> count == $past(count) + W'(1));
  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/memerr_event_decode.sv
module memerr_event_decode
  import memerr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int CH_W     = 2,
  parameter int SLOT_W   = 2,
  localparam int NUM_MOD = NUM_CH * NUM_SLOT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      err_valid,
  input  logic                      err_uncorr,
  input  logic                      err_has_loc,
  input  logic [CH_W-1:0]           err_chan,
  input  logic [SLOT_W-1:0]         err_slot,
  input  logic                      clr,
  output logic [NUM_MOD*KINDS-1:0]  mod_inc,
  output logic [NUM_SLOT*KINDS-1:0] slot_inc,
  output logic [KINDS-1:0]          tot_inc,
  output logic [KINDS-1:0]          ni_inc
);
  logic     act;
  logic     loc_ok;
  err_kind_e kind;

  assign act    = err_valid && !clr;
  assign kind   = err_kind_e'(err_uncorr);
  assign loc_ok = err_has_loc
                  && ({1'b0, err_chan} < (CH_W+1)'(NUM_CH))
                  && ({1'b0, err_slot} < (SLOT_W+1)'(NUM_SLOT));

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    logic kind_hit;
    assign kind_hit   = act && (kind == err_kind_e'(k));
    assign tot_inc[k] = kind_hit;
    assign ni_inc[k]  = kind_hit && !loc_ok;

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      assign mod_inc[m*KINDS + k] = kind_hit && loc_ok
        && (err_chan == CH_W'(m / NUM_SLOT))
        && (err_slot == SLOT_W'(m % NUM_SLOT));
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
      assign slot_inc[s*KINDS + k] = kind_hit && loc_ok
        && (err_slot == SLOT_W'(s));
    end
  end

  assert_one_module_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mod_inc));
  assert_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_inc));
  assert_total_matches_R3: assert property (@(posedge clk) disable iff (rst)
    (|tot_inc) == ((|mod_inc) || (|ni_inc)));
  assert_noloc_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    (|ni_inc) |-> !(|mod_inc) && !(|slot_inc));
  assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    clr |-> !(|tot_inc) && !(|mod_inc) && !(|slot_inc));
endmodule

// File: rtl/memerr_read_port.sv
module memerr_read_port #(
  parameter int NUM_REG = 29,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  regs [NUM_REG],
  output logic [CNT_W-1:0]  rd_data
);
  logic             in_map;
  logic [CNT_W-1:0] sel;

  assign in_map = {1'b0, rd_addr} < (ADDR_W+1)'(NUM_REG);

  always_comb begin
    sel = '0;
    if (in_map)
      sel = regs[rd_addr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= sel;
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_map) |=> rd_data == '0);
endmodule

// File: rtl/memerr_count_bank.sv
module memerr_count_bank
  import memerr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int CNT_W    = 16,
  parameter int CH_W     = 2,
  parameter int SLOT_W   = 2,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic              err_uncorr,
  input  logic              err_has_loc,
  input  logic [CH_W-1:0]   err_chan,
  input  logic [SLOT_W-1:0] err_slot,
  input  logic              sec_tick,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NUM_MOD   = NUM_CH * NUM_SLOT;
  localparam int MOD_REGS  = NUM_MOD * KINDS;
  localparam int SLOT_BASE = MOD_REGS;
  localparam int TOT_BASE  = SLOT_BASE + NUM_SLOT * KINDS;
  localparam int NI_BASE   = TOT_BASE + KINDS;
  localparam int SEC_IDX   = NI_BASE + KINDS;
  localparam int NUM_REG   = SEC_IDX + 1;

  logic [MOD_REGS-1:0]       mod_inc;
  logic [NUM_SLOT*KINDS-1:0] slot_inc;
  logic [KINDS-1:0]          tot_inc;
  logic [KINDS-1:0]          ni_inc;
  logic [CNT_W-1:0]          regs [NUM_REG];

  memerr_event_decode #(
    .NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .CH_W(CH_W), .SLOT_W(SLOT_W)
  ) u_decode (
    .clk(clk), .rst(rst),
    .err_valid(err_valid), .err_uncorr(err_uncorr),
    .err_has_loc(err_has_loc), .err_chan(err_chan), .err_slot(err_slot),
    .clr(clr),
    .mod_inc(mod_inc), .slot_inc(slot_inc),
    .tot_inc(tot_inc), .ni_inc(ni_inc)
  );

  for (genvar g = 0; g < MOD_REGS; g++) begin : g_mod_ctr
    memerr_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .clr(clr), .inc(mod_inc[g]), .count(regs[g])
    );
  end

  for (genvar g = 0; g < NUM_SLOT*KINDS; g++) begin : g_slot_ctr
    memerr_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .clr(clr), .inc(slot_inc[g]),
      .count(regs[SLOT_BASE+g])
    );
  end

  for (genvar k = 0; k < KINDS; k++) begin : g_sum_ctr
    memerr_sat_ctr #(.W(CNT_W)) u_tot (
      .clk(clk), .rst(rst), .clr(clr), .inc(tot_inc[k]),
      .count(regs[TOT_BASE+k])
    );
    memerr_sat_ctr #(.W(CNT_W)) u_ni (
      .clk(clk), .rst(rst), .clr(clr), .inc(ni_inc[k]),
      .count(regs[NI_BASE+k])
    );
  end

  memerr_sat_ctr #(.W(CNT_W)) u_seconds (
    .clk(clk), .rst(rst), .clr(clr), .inc(sec_tick && !clr),
    .count(regs[SEC_IDX])
  );

  memerr_read_port #(
    .NUM_REG(NUM_REG), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .regs(regs), .rd_data(rd_data)
  );

  assert_tick_counts_R5: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !clr && regs[SEC_IDX] != {CNT_W{1'b1}})
      |=> regs[SEC_IDX] == $past(regs[SEC_IDX]) + CNT_W'(1));
endmodule

// File: tb/test_memerr_count_bank.sv
`timescale 1ns/1ps
module test_memerr_count_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0, err_uncorr = 1'b0, err_has_loc = 1'b0;
  logic [1:0]  err_chan = '0, err_slot = '0;
  logic        sec_tick = 1'b0, clr = 1'b0, rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int expv [32];

  always #4 clk = ~clk;

  memerr_count_bank i_memerr_count_bank (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_uncorr(err_uncorr),
    .err_has_loc(err_has_loc), .err_chan(err_chan), .err_slot(err_slot),
    .sec_tick(sec_tick), .clr(clr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // {tick, uncorr, has_loc, chan[1:0], slot[1:0]}
  localparam logic [6:0] VEC [12] = '{
    7'b0_0_1_00_00, 7'b1_0_1_01_00, 7'b0_1_1_10_00, 7'b0_1_1_10_10,
    7'b1_0_1_01_01, 7'b0_1_1_00_10, 7'b0_0_0_01_01, 7'b1_1_0_10_10,
    7'b0_0_1_11_00, 7'b0_1_1_00_11, 7'b1_0_1_10_01, 7'b0_1_1_01_10
  };

  function automatic string tag_of(int a);
    if (a < 18) return "R1";
    if (a < 24) return "R2";
    if (a < 26) return "R3";
    if (a < 28) return "R4";
    if (a == 28) return "R5";
    return "R9";
  endfunction

  function automatic void bump(int a);
    if (expv[a] < 65535) expv[a]++;
  endfunction

  task automatic check(string tag, int got, int want);
    checks++;
    if (got != want) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, want);
    end
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic check_all(string ctx);
    int v;
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      check({tag_of(a), " ", ctx}, v, expv[a]);
    end
  endtask

  task automatic apply(logic [6:0] e);
    int k, ch, sl;
    @(negedge clk);
    sec_tick = e[6]; err_valid = 1'b1; err_uncorr = e[5];
    err_has_loc = e[4]; err_chan = e[3:2]; err_slot = e[1:0];
    @(negedge clk);
    err_valid = 1'b0; sec_tick = 1'b0;
    k = int'(e[5]); ch = int'(e[3:2]); sl = int'(e[1:0]);
    if (e[6]) bump(28);
    bump(24 + k);
    if (e[4] && ch < 3 && sl < 3) begin
      bump((ch*3 + sl)*2 + k);
      bump(18 + sl*2 + k);
    end else
      bump(26 + k);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    foreach (expv[i]) expv[i] = 0;
  endtask

  initial begin
    int v, held;
    foreach (expv[i]) expv[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rd_data after reset", int'(rd_data), 0);
    check_all("reset state R10");

    foreach (VEC[i]) apply(VEC[i]);
    check_all("table");

    // R9: rd_data holds while rd_en low
    rd(24, held);
    @(negedge clk); rd_addr = 5'd0;
    apply(7'b0_0_1_00_00);
    repeat (2) @(negedge clk);
    check("R9 hold while idle", int'(rd_data), held);

    do_clear();
    check_all("after clear R6");

    // R7: clear together with event and tick
    apply(7'b1_1_1_01_01);
    @(negedge clk);
    clr = 1'b1; err_valid = 1'b1; err_uncorr = 1'b0; err_has_loc = 1'b1;
    err_chan = 2'd1; err_slot = 2'd1; sec_tick = 1'b1;
    @(negedge clk);
    clr = 1'b0; err_valid = 1'b0; sec_tick = 1'b0;
    foreach (expv[i]) expv[i] = 0;
    check_all("clear priority R7");

    // R8: saturation of counters and seconds
    @(negedge clk);
    err_valid = 1'b1; err_uncorr = 1'b0; err_has_loc = 1'b1;
    err_chan = 2'd2; err_slot = 2'd2; sec_tick = 1'b1;
    repeat (65540) @(negedge clk);
    err_valid = 1'b0; sec_tick = 1'b0;
    rd(16, v); check("R8 module saturates", v, 16'hFFFF);
    rd(22, v); check("R8 slot saturates", v, 16'hFFFF);
    rd(24, v); check("R8 total saturates", v, 16'hFFFF);
    rd(28, v); check("R8 seconds saturate", v, 16'hFFFF);
    rd(17, v); check("R8 other kind untouched", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule